// File: doc/BRIEF.md
# Indirect Memory Access Window

This block lets a host reach a local word-organised memory through two registers on a simple 32-bit register bus. One register is a pointer-and-mode register. It holds a block number, a word offset inside that block, and two independent auto-advance enables: one for data writes and one for data reads. The other register is a data port. Each write to it stores a word at the pointed location. Each read of it returns the word at the pointed location.

A typical host sequence has two steps. First it loads the pointer register, with the write-advance bit set and every other field zero, which starts a burst at block 0, word 0. It then writes the data port once per 32-bit word. Reading back is the same, with the read-advance bit set instead. Because the two enables are separate, a pointer can stream in one direction while accesses in the other direction leave it where it is.

Each block holds 64 words, and the pointer's block field is 8 bits wide. The backing array holds `2**MEM_BLK_W` blocks. Byte `n` of a word (lowest byte address first) sits in bits `8n+7:8n`.

Top module: `memwin_port`

## Requirements
- R1: The pointer register decodes at bus byte address `CTRL_ADDR` (default 0xAC0) and the data port at `DATA_ADDR` (default 0xAC4). A write to any other address changes nothing, and a read of any other address returns zero.
- R2: Pointer register layout: bits 7:2 are the word offset, bits 15:8 are the block, bit 24 is write-advance and bit 25 is read-advance. A read returns the live pointer and both enables, with bits 1:0, 23:16 and 31:26 as zero.
- R3: A data-port write stores `bus_wdata` at the pointed word. When write-advance is set, that write also moves the pointer on by one word.
- R4: A data-port read returns the pointed word on `bus_rdata` in the cycle after the strobe. When read-advance is set, the pointer moves on by one word at that same edge, so reads on consecutive cycles return consecutive words.
- R5: A data access in a direction whose advance bit is clear leaves the pointer unchanged.
- R6: Advancing from word 63 gives word 0 of the next block. Advancing from block 255, word 63 gives block 0, word 0.
- R7: `bus_rdata` holds its value in every cycle without a read strobe.
- R8: Synchronous reset clears the pointer, both enables and `bus_rdata`.
- R9: The array holds `2**MEM_BLK_W` blocks (default 8). A block number is used modulo that count, so block 255 and block 7 name the same storage by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Register byte address |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_re` |

## Verification
A corrupted pointer cannot be seen directly on the data path, but it shows up at the ports one cycle after the next pointer-register read, because that read returns the live pointer. A wrong advance, or a stray advance in the disabled direction, therefore appears as a wrong offset or block there. It also appears as a wrong word returned by the very next data read. Array corruption shows up only when the affected word is read back, which is one cycle after the strobe. Wrap and aliasing faults are exposed by writing at the last word of a block and then reading the neighbouring location, or the aliased block, through a freshly loaded pointer.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    localparam int WORD_W   = 32;
    localparam int OFFS_W   = 6;
    localparam int BLK_W    = 8;
    localparam int PTR_W    = OFFS_W + BLK_W;

    localparam int OFFS_LSB = 2;
    localparam int BLK_LSB  = OFFS_LSB + OFFS_W;
    localparam int INCW_BIT = 24;
    localparam int INCR_BIT = 25;

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [OFFS_W-1:0] offs;
    } ptr_t;

    typedef struct packed {
        logic inc_rd;
        logic inc_wr;
        ptr_t ptr;
    } win_state_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2
    } sel_e;

    function automatic ptr_t ptr_advance(input ptr_t p);
        logic [PTR_W-1:0] flat;
        flat = p;
        flat = flat + PTR_W'(1);
        return ptr_t'(flat);
    endfunction

    function automatic win_state_t ctrl_unpack(input logic [WORD_W-1:0] w);
        win_state_t s;
        s.ptr.offs = w[OFFS_LSB +: OFFS_W];
        s.ptr.blk  = w[BLK_LSB +: BLK_W];
        s.inc_wr   = w[INCW_BIT];
        s.inc_rd   = w[INCR_BIT];
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_pack(input win_state_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[OFFS_LSB +: OFFS_W] = s.ptr.offs;
        w[BLK_LSB +: BLK_W]   = s.ptr.blk;
        w[INCW_BIT]           = s.inc_wr;
        w[INCR_BIT]           = s.inc_rd;
        return w;
    endfunction

endpackage

// File: rtl/memwin_decode.sv
module memwin_decode
    import memwin_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hAC0,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 12'hAC4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output sel_e              sel,
    output logic              ctrl_wr,
    output logic              data_wr,
    output logic              data_rd
);

    always_comb begin
        if (addr == CTRL_ADDR)      sel = SEL_CTRL;
        else if (addr == DATA_ADDR) sel = SEL_DATA;
        else                        sel = SEL_NONE;
    end

    assign ctrl_wr = we && (sel == SEL_CTRL);
    assign data_wr = we && (sel == SEL_DATA);
    assign data_rd = re && (sel == SEL_DATA);

endmodule

// File: rtl/memwin_ptr.sv
module memwin_ptr
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              data_wr,
    input  logic              data_rd,
    output win_state_t        state
);

    win_state_t state_q;
    logic       step;

    // one step per cycle even if both directions strobe together
    assign step = (data_wr && state_q.inc_wr) || (data_rd && state_q.inc_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (ctrl_wr) begin
            state_q <= ctrl_unpack(wdata);
        end else if (step) begin
            state_q.ptr <= ptr_advance(state_q.ptr);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/memwin_mem.sv
module memwin_mem
    import memwin_pkg::*;
#(
    parameter int MEM_BLK_W = 3,
    localparam int IDX_W    = MEM_BLK_W + OFFS_W,
    localparam int DEPTH    = 1 << IDX_W
) (
    input  logic              clk,
    input  ptr_t              ptr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] cells [DEPTH];

    generate
        if (MEM_BLK_W >= BLK_W) begin : g_full
            assign idx = IDX_W'(ptr);
        end else begin : g_alias
            assign idx = {ptr.blk[MEM_BLK_W-1:0], ptr.offs};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= wr_data;
    end

    assign rd_data = cells[idx];

endmodule

// File: rtl/memwin_port.sv
module memwin_port
    import memwin_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hAC0,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 12'hAC4,
    parameter int                MEM_BLK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata
);

    sel_e              sel;
    logic              ctrl_wr;
    logic              data_wr;
    logic              data_rd;
    win_state_t        win_q;
    logic [WORD_W-1:0] mem_word;
    logic [WORD_W-1:0] rd_next;
    logic [WORD_W-1:0] rdata_q;
    logic [PTR_W-1:0]  ptr_flat;

    memwin_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) i_decode (
        .addr    (bus_addr),
        .we      (bus_we),
        .re      (bus_re),
        .sel     (sel),
        .ctrl_wr (ctrl_wr),
        .data_wr (data_wr),
        .data_rd (data_rd)
    );

    memwin_ptr i_ptr (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .state   (win_q)
    );

    memwin_mem #(
        .MEM_BLK_W (MEM_BLK_W)
    ) i_mem (
        .clk     (clk),
        .ptr     (win_q.ptr),
        .wr_en   (data_wr),
        .wr_data (bus_wdata),
        .rd_data (mem_word)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_next = ctrl_pack(win_q);
            SEL_DATA: rd_next = mem_word;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;
    assign ptr_flat  = win_q.ptr;

endmodule

// File: rtl/memwin_checker.sv
module memwin_checker #(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hAC0,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 12'hAC4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic [13:0]       ptr_q,
    input logic              inc_w,
    input logic              inc_r
);

    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d && !rst) begin
            AST_RESET_CLEAR: assert (bus_rdata == 32'h0 && ptr_q == 14'h0 && !inc_w && !inc_r); // R8
        end
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CTRL_ADDR) |=>
            (ptr_q == $past(bus_wdata[15:2]) && inc_w == $past(bus_wdata[24]) && inc_r == $past(bus_wdata[25]))); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == DATA_ADDR && ((bus_we && inc_w) || (bus_re && inc_r))) |=>
            (ptr_q == $past(ptr_q) + 14'd1)); // R6

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == DATA_ADDR && !(bus_we && inc_w) && !(bus_re && inc_r)) |=> $stable(ptr_q)); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr != CTRL_ADDR && bus_addr != DATA_ADDR) |=> (bus_rdata == 32'h0)); // R1

endmodule

bind memwin_port memwin_checker #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .DATA_ADDR (DATA_ADDR)
) i_memwin_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .ptr_q     (ptr_flat),
    .inc_w     (win_q.inc_wr),
    .inc_r     (win_q.inc_rd)
);

// File: tb/test_memwin_port.sv
module test_memwin_port;

    localparam logic [11:0] CA = 12'hAC0;
    localparam logic [11:0] DA = 12'hAC4;
    localparam int NV = 21;
    // entry: {is_read, addr, wdata, expected, requirement number}
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, CA,      32'h0100_0000, 32'h0,          4'd2}, // R2 start write burst
        {1'b0, DA,      32'h1111_1111, 32'h0,          4'd3},
        {1'b0, DA,      32'h2222_2222, 32'h0,          4'd3},
        {1'b0, DA,      32'h3333_3333, 32'h0,          4'd3},
        {1'b1, CA,      32'h0,         32'h0100_000C, 4'd3}, // R3 three steps
        {1'b0, CA,      32'h0200_0000, 32'h0,          4'd2}, // read burst
        {1'b1, DA,      32'h0,         32'h1111_1111, 4'd4}, // R4
        {1'b1, DA,      32'h0,         32'h2222_2222, 4'd4},
        {1'b0, DA,      32'hAAAA_AAAA, 32'h0,          4'd5}, // R5 write, no advance
        {1'b1, CA,      32'h0,         32'h0200_0008, 4'd5},
        {1'b1, DA,      32'h0,         32'hAAAA_AAAA, 4'd3},
        {1'b1, CA,      32'h0,         32'h0200_000C, 4'd4},
        {1'b0, CA,      32'h0000_0004, 32'h0,          4'd2}, // no advance, word 1
        {1'b1, DA,      32'h0,         32'h2222_2222, 4'd5}, // R5 read, no advance
        {1'b1, DA,      32'h0,         32'h2222_2222, 4'd5},
        {1'b1, CA,      32'h0,         32'h0000_0004, 4'd5},
        {1'b0, CA,      32'hFFFF_FFFF, 32'h0,          4'd2}, // R2 reserved bits
        {1'b1, CA,      32'h0,         32'h0300_FFFC, 4'd2},
        {1'b1, 12'h000, 32'h0,         32'h0,          4'd1}, // R1 unmapped read
        {1'b0, 12'hAC8, 32'h0000_0005, 32'h0,          4'd1}, // R1 unmapped write
        {1'b1, CA,      32'h0,         32'h0300_FFFC, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    memwin_port i_memwin_port (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 rdata after reset", bus_rdata, 32'h0);
        bus_rd(CA, v);
        check("R8 pointer after reset", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][80]) begin
                bus_rd(VEC[i][79:68], v);
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][35:4]);
            end else begin
                bus_wr(VEC[i][79:68], VEC[i][67:36]);
            end
        end

        // R4 back-to-back reads with the strobe held
        bus_wr(CA, 32'h0200_0000);
        @(negedge clk);
        bus_addr = DA; bus_re = 1'b1;
        @(negedge clk);
        check("R4 first streamed word", bus_rdata, 32'h1111_1111);
        @(negedge clk);
        bus_re = 1'b0;
        check("R4 second streamed word", bus_rdata, 32'h2222_2222);
        // R7 idle cycles keep the read data
        repeat (3) @(negedge clk);
        check("R7 rdata held", bus_rdata, 32'h2222_2222);

        // R6 offset wrap into next block
        bus_wr(CA, 32'h0100_01FC);
        bus_wr(DA, 32'hDEAD_BEEF);
        bus_rd(CA, v);
        check("R6 word 63 to next block", v, 32'h0100_0200);
        // R6 last block wraps to block 0
        bus_wr(CA, 32'h0100_FFFC);
        bus_wr(DA, 32'h0BAD_F00D);
        bus_rd(CA, v);
        check("R6 block 255 wraps to 0", v, 32'h0100_0000);
        // R9 block 255 aliases block 7
        bus_wr(CA, 32'h0000_07FC);
        bus_rd(DA, v);
        check("R9 alias of block 255", v, 32'h0BAD_F00D);
        bus_wr(CA, 32'h0000_01FC);
        bus_rd(DA, v2);
        check("R3 word stored at block 1 word 63", v2, 32'hDEAD_BEEF);

        // R8 reset in mid-run
        bus_wr(CA, 32'h0300_1234);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8 rdata cleared", bus_rdata, 32'h0);
        bus_rd(CA, v);
        check("R8 pointer and enables cleared", v, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule